// File: doc/BRIEF.md
# Completion-Queue Write-Pointer Manager

This block places completion descriptors into a circular ring in host memory. The ring is set up by the host through a small register file. That file holds a 32-bit ring origin, written as two 16-bit halves, and a last-slot index counted in 32-bit words. It also holds the producer (write) pointer, the consumer (read) pointer and an enable bit. The consumer pointer is advanced by host software as it processes entries. The slots from the consumer pointer up to the producer pointer hold descriptors that have been written and not yet processed.

A receive engine offers one descriptor at a time on a valid/ready port. When the block accepts a descriptor, it computes the byte address as origin plus four times the producer pointer and captures the address and data. It then presents a single-word write on a valid/ready memory port. On the cycle that write completes, the producer pointer steps by one slot. If the stepped value would pass the last-slot index, the pointer returns to slot 0. The block never accepts a descriptor that would make the producer pointer catch up with the consumer pointer, so no unprocessed entry is ever overwritten.

Top module: `dq_wptr_mgr`

## Requirements
- R1: After reset, every register reads back as zero, including both pointers and the enable bit; `mem_valid`, `desc_ready` and `q_not_empty` are low.
- R2: A host write with `reg_we` high stores `reg_wdata` in the register chosen by `reg_sel`: 0 origin low half, 1 origin high half, 2 last-slot index, 3 producer pointer, 4 consumer pointer, 5 control (bit 0 = enable). `reg_rdata` returns the selected register combinationally, zero-extended, and returns 0 for codes 6 and 7.
- R3: The write address equals {origin high, origin low} + 4 × producer pointer, computed modulo 2^32.
- R4: The cycle after a descriptor is accepted (`desc_valid` and `desc_ready` both high at a clock edge), `mem_valid` is high with the captured address and data. These stay unchanged until `mem_ready` is sampled high.
- R5: On the edge where `mem_valid` and `mem_ready` are both high, the producer pointer increases by one, and it changes at no other time except through R10.
- R6: If the incremented producer pointer is greater than the last-slot index, the pointer becomes 0 instead. This includes the case where the index is the largest value the pointer width can hold.
- R7: While the enable bit is 0, `desc_ready` is low and no new write starts; a write already in progress still completes.
- R8: `q_full` is high when the next producer pointer value (after wrap) equals the consumer pointer. While it is high, `desc_ready` is low.
- R9: `q_not_empty` is high exactly when the producer pointer differs from the consumer pointer.
- R10: A host write to the producer pointer takes effect only when the enable bit is 0 and no memory write is in progress; otherwise it is ignored.
- R11: The host may write the consumer pointer at any time, and the full status responds to it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | HALF_W | Host write data |
| reg_rdata | output | HALF_W | Readback of selected register |
| desc_valid | input | 1 | Descriptor offered |
| desc_data | input | DATA_W | Descriptor word |
| desc_ready | output | 1 | Descriptor accepted this cycle |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 2*HALF_W | Memory byte address |
| mem_data | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory write completion |
| q_full | output | 1 | Ring has no free slot |
| q_not_empty | output | 1 | Unprocessed entries present |

## Verification
The bench builds the block with a 6-bit pointer, 16-bit halves and 32-bit data, and leaves the readback combinational. The narrow pointer makes a last-slot index equal to the maximum pointer value (63) easy to program, so the wrap from the all-ones pointer back to zero is reached within a few descriptors. The origin is set close to the top of the 32-bit space, so the address sum rolls over as well. A short ring of six slots fills within a dozen cycles, which exercises the full stall and its release by a consumer-pointer write. A stretch with pseudo-random `mem_ready` exercises held requests.

// File: rtl/dq_pkg.sv
package dq_pkg;

   localparam int DQ_SEL_W = 3;

   typedef enum logic [DQ_SEL_W-1:0] {
      SEL_BASE_LO = 3'd0,
      SEL_BASE_HI = 3'd1,
      SEL_LAST    = 3'd2,
      SEL_WPTR    = 3'd3,
      SEL_RPTR    = 3'd4,
      SEL_CTRL    = 3'd5
   } dq_sel_e;

   typedef enum logic {
      XF_IDLE = 1'b0,
      XF_BUSY = 1'b1
   } dq_xfer_e;

endpackage

// File: rtl/dq_regfile.sv
module dq_regfile
   import dq_pkg::*;
#(
   parameter int HALF_W    = 16,
   parameter int PTR_W     = 16,
   parameter int REG_RDATA = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [DQ_SEL_W-1:0] reg_sel,
   input  logic [HALF_W-1:0]   reg_wdata,
   output logic [HALF_W-1:0]   reg_rdata,
   input  logic                busy,
   input  logic                adv,
   input  logic [PTR_W-1:0]    wp_next,
   output logic [2*HALF_W-1:0] base_addr,
   output logic [PTR_W-1:0]    last_idx,
   output logic [PTR_W-1:0]    wptr,
   output logic [PTR_W-1:0]    rptr,
   output logic                enable
);

   localparam int ADDR_W = 2 * HALF_W;

   logic [HALF_W-1:0] base_lo_q;
   logic [HALF_W-1:0] base_hi_q;
   logic [PTR_W-1:0]  last_q;
   logic [PTR_W-1:0]  wp_q;
   logic [PTR_W-1:0]  rp_q;
   logic              en_q;
   logic              wp_wr_ok;
   logic [HALF_W-1:0] rd_mux;

   // producer pointer is host-writable only when the engine is off and idle
   assign wp_wr_ok = !en_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         last_q    <= '0;
         wp_q      <= '0;
         rp_q      <= '0;
         en_q      <= 1'b0;
      end else begin
         if (reg_we) begin
            case (dq_sel_e'(reg_sel))
               SEL_BASE_LO: base_lo_q <= reg_wdata;
               SEL_BASE_HI: base_hi_q <= reg_wdata;
               SEL_LAST:    last_q    <= reg_wdata[PTR_W-1:0];
               SEL_WPTR:    if (wp_wr_ok) wp_q <= reg_wdata[PTR_W-1:0];
               SEL_RPTR:    rp_q      <= reg_wdata[PTR_W-1:0];
               SEL_CTRL:    en_q      <= reg_wdata[0];
               default:     ;
            endcase
         end
         if (adv) begin
            wp_q <= wp_next;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (dq_sel_e'(reg_sel))
         SEL_BASE_LO: rd_mux = base_lo_q;
         SEL_BASE_HI: rd_mux = base_hi_q;
         SEL_LAST:    rd_mux[PTR_W-1:0] = last_q;
         SEL_WPTR:    rd_mux[PTR_W-1:0] = wp_q;
         SEL_RPTR:    rd_mux[PTR_W-1:0] = rp_q;
         SEL_CTRL:    rd_mux[0] = en_q;
         default:     rd_mux = '0;
      endcase
   end

   generate
      if (REG_RDATA != 0) begin : g_rd_reg
         logic [HALF_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   assign base_addr = {base_hi_q, base_lo_q};
   assign last_idx  = last_q;
   assign wptr      = wp_q;
   assign rptr      = rp_q;
   assign enable    = en_q;

   generate
      if (ADDR_W != 2 * HALF_W) begin : g_bad_addr
         $error("dq_regfile: origin width mismatch");
      end
   endgenerate

endmodule

// File: rtl/dq_wrap_calc.sv
module dq_wrap_calc #(
   parameter int PTR_W = 16
) (
   input  logic [PTR_W-1:0] wptr,
   input  logic [PTR_W-1:0] last_idx,
   input  logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wp_next,
   output logic             full,
   output logic             not_empty
);

   localparam int EXT_W = PTR_W + 1;

   logic [EXT_W-1:0] inc_ext;
   logic [EXT_W-1:0] last_ext;
   logic             past_end;

   // one extra bit so that an all-ones pointer still compares above the index
   assign inc_ext  = {1'b0, wptr} + EXT_W'(1);
   assign last_ext = {1'b0, last_idx};
   assign past_end = inc_ext > last_ext;
   assign wp_next  = past_end ? '0 : inc_ext[PTR_W-1:0];

   assign full      = (wp_next == rptr);
   assign not_empty = (wptr != rptr);

endmodule

// File: rtl/dq_xfer_ctl.sv
module dq_xfer_ctl
   import dq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PTR_W      = 16,
   parameter int DATA_W     = 32,
   parameter int BYTE_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              full,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [PTR_W-1:0]  wptr,
   input  logic              desc_valid,
   input  logic [DATA_W-1:0] desc_data,
   output logic              desc_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ready,
   output logic              busy,
   output logic              adv
);

   dq_xfer_e          state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] ptr_ext;
   logic [ADDR_W-1:0] byte_ofs;
   logic [ADDR_W-1:0] slot_addr;
   logic              accept;

   always_comb begin
      ptr_ext = '0;
      ptr_ext[PTR_W-1:0] = wptr;
   end

   assign byte_ofs  = ptr_ext << BYTE_SHIFT;
   assign slot_addr = base_addr + byte_ofs;

   assign desc_ready = (state_q == XF_IDLE) && enable && !full;
   assign accept     = desc_valid && desc_ready;
   assign busy       = (state_q == XF_BUSY);
   assign adv        = busy && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            XF_IDLE: begin
               if (accept) begin
                  addr_q  <= slot_addr;
                  data_q  <= desc_data;
                  state_q <= XF_BUSY;
               end
            end
            XF_BUSY: begin
               if (mem_ready) begin
                  state_q <= XF_IDLE;
               end
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign mem_valid = busy;
   assign mem_addr  = addr_q;
   assign mem_data  = data_q;

endmodule

// File: rtl/dq_wptr_mgr.sv
module dq_wptr_mgr
   import dq_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter int PTR_W      = 16,
   parameter int DATA_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int REG_RDATA  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [2:0]          reg_sel,
   input  logic [HALF_W-1:0]   reg_wdata,
   output logic [HALF_W-1:0]   reg_rdata,
   input  logic                desc_valid,
   input  logic [DATA_W-1:0]   desc_data,
   output logic                desc_ready,
   output logic                mem_valid,
   output logic [2*HALF_W-1:0] mem_addr,
   output logic [DATA_W-1:0]   mem_data,
   input  logic                mem_ready,
   output logic                q_full,
   output logic                q_not_empty
);

   localparam int ADDR_W     = 2 * HALF_W;
   localparam int BYTE_SHIFT = $clog2(WORD_BYTES);

   generate
      if (PTR_W < 1 || PTR_W > HALF_W) begin : g_bad_ptr
         $error("dq_wptr_mgr: PTR_W must be 1..HALF_W");
      end
      if (WORD_BYTES < 1 || (1 << BYTE_SHIFT) != WORD_BYTES) begin : g_bad_word
         $error("dq_wptr_mgr: WORD_BYTES must be a power of two");
      end
      if (PTR_W + BYTE_SHIFT > ADDR_W) begin : g_bad_span
         $error("dq_wptr_mgr: ring span exceeds address width");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr;
   logic [PTR_W-1:0]  last_idx;
   logic [PTR_W-1:0]  wptr_q;
   logic [PTR_W-1:0]  rptr_q;
   logic [PTR_W-1:0]  wp_next;
   logic              ctl_en;
   logic              full;
   logic              not_empty;
   logic              busy;
   logic              adv;

   dq_regfile #(
      .HALF_W    (HALF_W),
      .PTR_W     (PTR_W),
      .REG_RDATA (REG_RDATA)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .adv       (adv),
      .wp_next   (wp_next),
      .base_addr (base_addr),
      .last_idx  (last_idx),
      .wptr      (wptr_q),
      .rptr      (rptr_q),
      .enable    (ctl_en)
   );

   dq_wrap_calc #(
      .PTR_W (PTR_W)
   ) u_wrap (
      .wptr      (wptr_q),
      .last_idx  (last_idx),
      .rptr      (rptr_q),
      .wp_next   (wp_next),
      .full      (full),
      .not_empty (not_empty)
   );

   dq_xfer_ctl #(
      .ADDR_W     (ADDR_W),
      .PTR_W      (PTR_W),
      .DATA_W     (DATA_W),
      .BYTE_SHIFT (BYTE_SHIFT)
   ) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ctl_en),
      .full       (full),
      .base_addr  (base_addr),
      .wptr       (wptr_q),
      .desc_valid (desc_valid),
      .desc_data  (desc_data),
      .desc_ready (desc_ready),
      .mem_valid  (mem_valid),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data),
      .mem_ready  (mem_ready),
      .busy       (busy),
      .adv        (adv)
   );

   assign q_full      = full;
   assign q_not_empty = not_empty;

endmodule

// File: rtl/dq_wptr_mgr_chk.sv
module dq_wptr_mgr_chk #(
   parameter int ADDR_W = 32,
   parameter int PTR_W  = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_sel,
   input logic              desc_valid,
   input logic              desc_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic              q_full,
   input logic              enable,
   input logic [PTR_W-1:0]  wptr,
   input logic [PTR_W-1:0]  last_idx
);

   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

   a_r4_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready |=> mem_valid);

   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && (wptr < last_idx) |=> wptr == $past(wptr) + 1'b1);

   a_r5_no_stray_move: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !(mem_valid && mem_ready) |=> $stable(wptr));

   a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && (wptr >= last_idx) |=> wptr == '0);

   a_r7_off_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !desc_ready);

   a_r8_full_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !desc_ready);

   a_r10_wptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && (reg_sel == 3'd3) && mem_valid && !mem_ready |=> $stable(wptr));

endmodule

bind dq_wptr_mgr dq_wptr_mgr_chk #(
   .ADDR_W (ADDR_W),
   .PTR_W  (PTR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_sel    (reg_sel),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .mem_valid  (mem_valid),
   .mem_ready  (mem_ready),
   .mem_addr   (mem_addr),
   .mem_data   (mem_data),
   .q_full     (q_full),
   .enable     (ctl_en),
   .wptr       (wptr_q),
   .last_idx   (last_idx)
);

// File: tb/dq_wptr_mgr_tb_top.sv
`timescale 1ns/1ps
module dq_wptr_mgr_tb_top;

   localparam int HALF_W = 16;
   localparam int PTR_W  = 6;
   localparam int DATA_W = 32;
   localparam int PMASK  = (1 << PTR_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_sel = 3'd0;
   logic [HALF_W-1:0] reg_wdata = '0;
   logic [HALF_W-1:0] reg_rdata;
   logic              desc_valid = 1'b0;
   logic [DATA_W-1:0] desc_data = 32'hD000_0000;
   logic              desc_ready;
   logic              mem_valid;
   logic [31:0]       mem_addr;
   logic [DATA_W-1:0] mem_data;
   logic              mem_ready = 1'b1;
   logic              q_full;
   logic              q_not_empty;

   always #10 clk = ~clk;

   dq_wptr_mgr #(
      .HALF_W (HALF_W),
      .PTR_W  (PTR_W),
      .DATA_W (DATA_W)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_sel     (reg_sel),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .desc_valid  (desc_valid),
      .desc_data   (desc_data),
      .desc_ready  (desc_ready),
      .mem_valid   (mem_valid),
      .mem_addr    (mem_addr),
      .mem_data    (mem_data),
      .mem_ready   (mem_ready),
      .q_full      (q_full),
      .q_not_empty (q_not_empty)
   );

   int checks = 0;
   int failures = 0;
   bit in_rst = 1'b1;

   // reference model state
   int          m_blo, m_bhi, m_last, m_wp, m_rp;
   bit          m_en, m_busy, m_acc;
   logic [31:0] m_addr, m_data;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int m_next();
      return (m_wp + 1 > m_last) ? 0 : m_wp + 1;
   endfunction

   function automatic bit m_full();
      return m_next() == m_rp;
   endfunction

   function automatic bit m_ready();
      return !m_busy && m_en && !m_full();
   endfunction

   function automatic logic [31:0] m_rd(int sel);
      case (sel)
         0: return m_blo;
         1: return m_bhi;
         2: return m_last;
         3: return m_wp;
         4: return m_rp;
         5: return {31'd0, m_en};
         default: return 32'd0;
      endcase
   endfunction

   task automatic compare();
      chk("R8 desc_ready", desc_ready, m_ready());
      chk("R4 mem_valid", mem_valid, m_busy);
      if (m_busy) begin
         chk("R3 mem_addr", mem_addr, m_addr);
         chk("R4 mem_data", mem_data, m_data);
      end
      chk("R8 q_full", q_full, m_full());
      chk("R9 q_not_empty", q_not_empty, m_wp != m_rp);
      chk("R2 reg_rdata", reg_rdata, m_rd(reg_sel));
   endtask

   task automatic model_step();
      bit old_en, old_busy, rdy;
      int nxt;
      old_en   = m_en;
      old_busy = m_busy;
      rdy      = m_ready();
      nxt      = m_next();
      m_acc    = 1'b0;
      if (m_busy) begin
         if (mem_ready) begin
            m_wp   = nxt;
            m_busy = 1'b0;
         end
      end else if (desc_valid && rdy) begin
         m_busy = 1'b1;
         m_acc  = 1'b1;
         m_addr = {m_bhi[15:0], m_blo[15:0]} + (32'(m_wp) << 2);
         m_data = desc_data;
      end
      if (reg_we) begin
         case (reg_sel)
            3'd0: m_blo  = reg_wdata;
            3'd1: m_bhi  = reg_wdata;
            3'd2: m_last = reg_wdata & PMASK;
            3'd3: if (!old_en && !old_busy) m_wp = reg_wdata & PMASK;
            3'd4: m_rp   = reg_wdata & PMASK;
            3'd5: m_en   = reg_wdata[0];
            default: ;
         endcase
      end
   endtask

   // inputs change just after the falling edge; outputs checked 1 ns later
   task automatic tick();
      #1;
      if (!in_rst) compare();
      @(posedge clk);
      if (!in_rst) model_step();
      @(negedge clk);
      if (m_acc) desc_data = desc_data + 32'h0101_0101;
   endtask

   task automatic wr(int sel, int val);
      reg_we    = 1'b1;
      reg_sel   = 3'(sel);
      reg_wdata = 16'(val);
      tick();
      reg_we    = 1'b0;
   endtask

   task automatic rd_check(string tag, int sel, int exp);
      reg_sel = 3'(sel);
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      m_blo = 0; m_bhi = 0; m_last = 0; m_wp = 0; m_rp = 0;
      m_en = 0; m_busy = 0; m_acc = 0; m_addr = 0; m_data = 0;
      repeat (3) @(negedge clk);
      rst_n  = 1'b1;
      in_rst = 1'b0;

      // R1: reset contents through readback and status
      for (int s = 0; s < 6; s++) rd_check("R1 reg after reset", s, 0);
      chk("R1 mem_valid", mem_valid, 1'b0);
      chk("R1 desc_ready", desc_ready, 1'b0);
      chk("R1 q_not_empty", q_not_empty, 1'b0);
      tick();

      // R2: program origin, six-slot ring, enable
      wr(0, 16'h0010);
      wr(1, 16'hABCD);
      wr(2, 5);
      wr(5, 1);
      rd_check("R2 origin low", 0, 16'h0010);
      rd_check("R2 origin high", 1, 16'hABCD);
      rd_check("R2 control", 5, 1);
      rd_check("R2 unused code", 6, 0);

      // R5/R8: stream until the ring fills
      desc_valid = 1'b1;
      mem_ready  = 1'b1;
      repeat (12) tick();
      desc_valid = 1'b0;
      rd_check("R5 producer after five writes", 3, 5);
      chk("R8 full after five", q_full, 1'b1);
      chk("R9 not empty", q_not_empty, 1'b1);

      // R11/R6: free space, wrap at index 5
      wr(4, 3);
      chk("R11 full released", q_full, 1'b0);
      desc_valid = 1'b1;
      repeat (12) tick();
      desc_valid = 1'b0;
      rd_check("R6 producer wrapped", 3, 2);

      // R9: empty ring, then random backpressure over a 64-slot ring
      wr(4, 2);
      chk("R9 empty", q_not_empty, 1'b0);
      wr(2, 63);
      desc_valid = 1'b1;
      for (int i = 0; i < 60; i++) begin
         mem_ready = lfsr[0];
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tick();
      end
      mem_ready = 1'b1;

      // R7: disable while offered
      wr(5, 0);
      tick();
      chk("R7 no ready when off", desc_ready, 1'b0);
      repeat (3) tick();
      chk("R7 no write when off", mem_valid, 1'b0);
      chk("R7 still no ready", desc_ready, 1'b0);
      desc_valid = 1'b0;

      // R10: write allowed when off, ignored when on
      wr(3, 62);
      rd_check("R10 producer write when off", 3, 62);
      wr(4, 5);
      wr(0, 16'hFFF0);
      wr(1, 16'hFFFF);
      wr(5, 1);
      wr(3, 10);
      rd_check("R10 producer write ignored", 3, 62);

      // R3/R4: address rollover and held request
      desc_valid = 1'b1;
      mem_ready  = 1'b0;
      tick();
      desc_valid = 1'b0;
      chk("R4 valid after accept", mem_valid, 1'b1);
      chk("R3 address rollover", mem_addr, 32'h0000_00E8);
      tick();
      tick();
      chk("R4 held valid", mem_valid, 1'b1);
      chk("R4 held address", mem_addr, 32'h0000_00E8);
      wr(3, 20);
      rd_check("R10 ignored while in flight", 3, 62);
      mem_ready = 1'b1;
      tick();
      rd_check("R5 producer step", 3, 63);

      // R6: wrap from all-ones pointer with index at maximum
      desc_valid = 1'b1;
      tick();
      tick();
      desc_valid = 1'b0;
      rd_check("R6 wrap from max", 3, 0);
      repeat (2) tick();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule